// File: doc/BRIEF.md
# Pulse-Coded Level Isolation Channel

This block carries a set of logic levels across a simulated pulse link, one independent lane per level. On the sending side an encoder watches each level and turns every change into a one-clock strobe: a set strobe when the level rises, a clear strobe when it falls. While a level sits still, the encoder repeats its current value as a refresh strobe at a fixed interval. A receiver that joins late, or that misses a strobe, therefore still settles on the correct level.

On the receiving side each lane has a bistable decoder. A set strobe drives the lane's output high and a clear strobe drives it low. A watchdog counts the cycles since the last strobe. When strobes stop for longer than a parameterised limit, it treats the sender as dead and forces the lane to its own fail-safe level. A data lane defaults high, so a dead sender reads as an idle line. An enable lane defaults low, so a line driver it controls releases the bus.

A power-good input on the sending side silences every encoder. The link is exposed as separate transmit and receive strobe ports, so the system joins them and can inject faults between them. All intervals are counted in system clock cycles.

Top module: `pulse_iso_channel`

## Requirements
- R1: A level change on lane i, sampled at a clock edge while powered, gives a one-cycle strobe on that lane in the next cycle: `tx_set_strb[i]` when the new level is 1, `tx_clr_strb[i]` when it is 0.
- R2: A lone set strobe on `rx_set_strb[i]` drives `rx_level[i]` to 1 on the next clock edge, and a lone clear strobe on `rx_clr_strb[i]` drives it to 0. With the link looped back, a level change therefore reaches `rx_level` two cycles after it is sampled.
- R3: While a powered lane's level is unchanged, the encoder repeats a strobe encoding the current level every REFRESH_CYCLES cycles, counted from the lane's previous strobe. An edge restarts this interval.
- R4: After reset, each decoder output holds its default level until the first strobe arrives. In the first cycle after reset is released with power good, the encoder sends a strobe encoding the current level.
- R5: While `tx_pwr_good` is 0, no strobe is emitted on any lane. When power returns, the first powered cycle sends a strobe encoding the current level.
- R6: Once a lane has received no valid strobe for TIMEOUT_CYCLES consecutive clock edges, its output goes to the default level and stays there. Any later valid strobe takes the lane out of this state at once and restarts the count.
- R7: The default level of lane i is bit i of DEFAULT_LEVELS. With the default value 2'b01, lane 0 (data) defaults to 1 and lane 1 (enable) defaults to 0.
- R8: A set and a clear strobe arriving on one lane in the same cycle leave that lane's output unchanged for that edge and set `rx_fault[i]`, which stays set until reset. Such a collision does not count as a valid strobe for the watchdog.
- R9: The encoder never raises `tx_set_strb[i]` and `tx_clr_strb[i]` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pwr_good | input | 1 | Sending side powered; 0 silences all encoders |
| tx_level | input | LANES | Levels to transport |
| tx_set_strb | output | LANES | Encoder set strobes onto the link |
| tx_clr_strb | output | LANES | Encoder clear strobes onto the link |
| rx_set_strb | input | LANES | Set strobes arriving from the link |
| rx_clr_strb | input | LANES | Clear strobes arriving from the link |
| rx_level | output | LANES | Decoded levels |
| rx_fault | output | LANES | Sticky same-cycle set/clear collision flag |

## Verification
The bench builds the block with two lanes, REFRESH_CYCLES of 8 and TIMEOUT_CYCLES of 20, keeping DEFAULT_LEVELS at 2'b01. These short intervals let it sweep every pair of two-bit levels with hold times just below, at and just above one refresh interval. The same run holds levels across several refresh periods, lets the watchdog expire on both defaults, and injects collisions and lone strobes onto the looped-back link. A cycle-level reference built from the requirements is compared with every strobe and output in every cycle, and directed checks pin down the two-cycle latency and the expiry within TIMEOUT_CYCLES plus one cycle after power is lost.

// File: rtl/pulse_iso_pkg.sv
package pulse_iso_pkg;

  // Strobe pair carried on one lane of the link.
  typedef struct packed {
    logic set;
    logic clr;
  } strobe_t;

  // Width of a counter that must hold the values 0..limit-1.
  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/pulse_iso_encoder.sv
module pulse_iso_encoder #(
  parameter int REFRESH_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good_i,
  input  logic lvl_i,
  output logic set_o,
  output logic clr_o
);
  import pulse_iso_pkg::*;

  localparam int CW = cnt_bits(REFRESH_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(REFRESH_CYCLES - 1);

  logic [CW-1:0] since_q;
  logic          prev_q;
  logic          fresh_q;   // first powered cycle pending
  logic          level_moved;
  logic          refresh_due;
  logic          send_now;

  assign level_moved = (lvl_i != prev_q) && !fresh_q;
  assign refresh_due = (since_q == LAST);
  assign send_now    = fresh_q || level_moved || refresh_due;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      prev_q  <= 1'b0;
      fresh_q <= 1'b1;
      set_o   <= 1'b0;
      clr_o   <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      set_o  <= 1'b0;
      clr_o  <= 1'b0;
      if (!pwr_good_i) begin
        since_q <= '0;
        fresh_q <= 1'b1;
      end else if (send_now) begin
        set_o   <= lvl_i;
        clr_o   <= !lvl_i;
        since_q <= '0;
        fresh_q <= 1'b0;
      end else begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  p_rise_sets_r1: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && !fresh_q && lvl_i && !prev_q) |=> (set_o && !clr_o));

  p_fall_clears_r1: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && !fresh_q && !lvl_i && prev_q) |=> (clr_o && !set_o));

  p_silent_unpowered_r5: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_i |=> (!set_o && !clr_o));

  p_wakeup_refresh_r4: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && fresh_q) |=> (set_o || clr_o));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(set_o && clr_o));

endmodule

// File: rtl/pulse_iso_decoder.sv
module pulse_iso_decoder #(
  parameter int   TIMEOUT_CYCLES = 1000,
  parameter logic DEFAULT_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic lvl_o,
  output logic fault_o
);
  import pulse_iso_pkg::*;

  localparam int CW = cnt_bits(TIMEOUT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  strobe_t       rx;
  logic [CW-1:0] quiet_q;
  logic          expired;

  assign rx      = '{set: set_i, clr: clr_i};
  assign expired = (quiet_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o   <= DEFAULT_LEVEL;
      quiet_q <= '0;
      fault_o <= 1'b0;
    end else begin
      unique case ({rx.set, rx.clr})
        2'b11: begin
          fault_o <= 1'b1;
          if (!expired) quiet_q <= quiet_q + 1'b1;
        end
        2'b10, 2'b01: begin
          lvl_o   <= rx.set;
          quiet_q <= '0;
        end
        default: begin
          if (expired) lvl_o <= DEFAULT_LEVEL;
          else         quiet_q <= quiet_q + 1'b1;
        end
      endcase
    end
  end

  p_set_drives_high_r2: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> lvl_o);

  p_clr_drives_low_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !lvl_o);

  p_starved_default_r6: assert property (@(posedge clk) disable iff (rst)
    (expired && !set_i && !clr_i) |=> (lvl_o == DEFAULT_LEVEL));

  p_collision_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> ($stable(lvl_o) && fault_o));

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> fault_o);

endmodule

// File: rtl/pulse_iso_channel.sv
module pulse_iso_channel #(
  parameter int             LANES          = 2,
  parameter int             REFRESH_CYCLES = 200,
  parameter int             TIMEOUT_CYCLES = 1000,
  parameter logic [LANES-1:0] DEFAULT_LEVELS = 2'b01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_pwr_good,
  input  logic [LANES-1:0] tx_level,
  output logic [LANES-1:0] tx_set_strb,
  output logic [LANES-1:0] tx_clr_strb,
  input  logic [LANES-1:0] rx_set_strb,
  input  logic [LANES-1:0] rx_clr_strb,
  output logic [LANES-1:0] rx_level,
  output logic [LANES-1:0] rx_fault
);

  initial begin
    a_interval_order_r6: assert (TIMEOUT_CYCLES > REFRESH_CYCLES && REFRESH_CYCLES >= 2);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pulse_iso_encoder #(
      .REFRESH_CYCLES(REFRESH_CYCLES)
    ) u_enc (
      .clk        (clk),
      .rst        (rst),
      .pwr_good_i (tx_pwr_good),
      .lvl_i      (tx_level[g]),
      .set_o      (tx_set_strb[g]),
      .clr_o      (tx_clr_strb[g])
    );

    pulse_iso_decoder #(
      .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
      .DEFAULT_LEVEL (DEFAULT_LEVELS[g])
    ) u_dec (
      .clk     (clk),
      .rst     (rst),
      .set_i   (rx_set_strb[g]),
      .clr_i   (rx_clr_strb[g]),
      .lvl_o   (rx_level[g]),
      .fault_o (rx_fault[g])
    );
  end

endmodule

// File: tb/pulse_iso_channel_test.sv
module pulse_iso_channel_test;
  localparam int N = 2;
  localparam int R = 8;
  localparam int T = 20;
  localparam logic [N-1:0] DEF = 2'b01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr = 1'b1;
  logic [N-1:0] lvl = '0, inj_set = '0, inj_clr = '0;
  logic [N-1:0] tx_set, tx_clr, rx_level, rx_fault;

  always #2.5 clk = ~clk;

  pulse_iso_channel #(.LANES(N), .REFRESH_CYCLES(R), .TIMEOUT_CYCLES(T),
                      .DEFAULT_LEVELS(DEF)) uut (
    .clk(clk), .rst(rst), .tx_pwr_good(pwr), .tx_level(lvl),
    .tx_set_strb(tx_set), .tx_clr_strb(tx_clr),
    .rx_set_strb(tx_set | inj_set), .rx_clr_strb(tx_clr | inj_clr),
    .rx_level(rx_level), .rx_fault(rx_fault));

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state, built from the requirement text.
  logic [N-1:0] e_set = '0, e_clr = '0, e_out = DEF, e_fault = '0;
  logic [N-1:0] m_prev = '0, m_wake = '1;
  int m_since [N];
  int d_quiet [N];
  string e_tag [N];
  string d_tag [N];

  initial for (int i = 0; i < N; i++) begin
    m_since[i] = 0; d_quiet[i] = 0; e_tag[i] = "R4"; d_tag[i] = "R4";
  end

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      logic rs, rc;
      rs = e_set[i] | inj_set[i];
      rc = e_clr[i] | inj_clr[i];
      if (rst) begin
        e_out[i] = DEF[i]; e_fault[i] = 1'b0; d_quiet[i] = 0; d_tag[i] = "R4";
      end else if (rs && rc) begin
        e_fault[i] = 1'b1; d_tag[i] = "R8";
        if (d_quiet[i] < T - 1) d_quiet[i]++;
      end else if (rs || rc) begin
        e_out[i] = rs; d_quiet[i] = 0; d_tag[i] = "R2";
      end else if (d_quiet[i] == T - 1) begin
        e_out[i] = DEF[i]; d_tag[i] = "R6";
      end else d_quiet[i]++;

      e_set[i] = 1'b0; e_clr[i] = 1'b0;
      if (rst) begin
        m_wake[i] = 1'b1; m_since[i] = 0; m_prev[i] = 1'b0; e_tag[i] = "R4";
      end else if (!pwr) begin
        m_wake[i] = 1'b1; m_since[i] = 0; e_tag[i] = "R5";
      end else if (m_wake[i] || lvl[i] != m_prev[i] || m_since[i] == R - 1) begin
        e_tag[i] = m_wake[i] ? "R4" : (lvl[i] != m_prev[i]) ? "R1" : "R3";
        e_set[i] = lvl[i]; e_clr[i] = !lvl[i];
        m_wake[i] = 1'b0; m_since[i] = 0;
      end else begin
        m_since[i]++; e_tag[i] = "R3";
      end
      if (!rst) m_prev[i] = lvl[i];
    end
  end

  task automatic check(input string tag, input string what, input logic [N-1:0] got,
                       input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < N; i++) begin
        check(e_tag[i], $sformatf("lane%0d set strobe", i), N'(tx_set[i]), N'(e_set[i]));
        check(e_tag[i], $sformatf("lane%0d clr strobe", i), N'(tx_clr[i]), N'(e_clr[i]));
        check(d_tag[i], $sformatf("lane%0d level", i), N'(rx_level[i]), N'(e_out[i]));
        check("R8", $sformatf("lane%0d fault", i), N'(rx_fault[i]), N'(e_fault[i]));
      end
      check("R9", "strobe overlap", tx_set & tx_clr, '0);
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int holds [5];
    holds = '{1, 2, R - 1, R, R + 1};
    hold(3);
    check("R4", "level in reset", rx_level, DEF);
    check("R4", "strobes in reset", tx_set | tx_clr, '0);
    rst = 1'b0;
    hold(1);
    check("R4", "wake-up clear strobes", tx_clr, 2'b11);
    check("R4", "default before first strobe seen", rx_level, DEF);
    hold(1);
    check("R2", "level after wake-up strobe", rx_level, 2'b00);
    lvl = 2'b11;
    hold(1);
    check("R1", "rising edges give set strobes", tx_set, 2'b11);
    hold(1);
    check("R2", "two-cycle end-to-end latency", rx_level, 2'b11);
    lvl = 2'b01;
    hold(1);
    check("R1", "falling edge gives clear strobe", tx_clr, 2'b10);

    // Near-exhaustive transition sweep over both lanes.
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int h = 0; h < 5; h++) begin
          lvl = N'(a); hold(holds[h]);
          lvl = N'(b); hold(holds[h]);
        end

    // Steady level across many refresh periods.
    lvl = 2'b10;
    hold(5 * R);
    check("R3", "steady level held", rx_level, 2'b10);

    // Sender loses power: watchdog expiry.
    pwr = 1'b0;
    hold(T - R - 1);
    check("R6", "level held before expiry", rx_level, 2'b10);
    lvl = 2'b01;
    hold(R + 2);
    check("R7", "defaults after expiry", rx_level, 2'b01);
    check("R5", "no strobes while unpowered", tx_set | tx_clr, '0);

    // Collision and a lone strobe on the dead link.
    inj_set = 2'b11; inj_clr = 2'b11;
    hold(1);
    inj_set = '0; inj_clr = '0;
    check("R8", "fault after collision", rx_fault, 2'b11);
    check("R8", "level held over collision", rx_level, 2'b01);
    inj_set = 2'b10;
    hold(1);
    inj_set = '0;
    check("R6", "lone strobe leaves forced state", rx_level, 2'b11);
    hold(T + 1);
    check("R6", "forced again after new starvation", rx_level, 2'b01);

    // Power returns.
    lvl = 2'b10;
    pwr = 1'b1;
    hold(1);
    check("R5", "refresh on power return", tx_set, 2'b10);
    hold(3 * R);
    check("R8", "fault remains sticky", rx_fault, 2'b11);
    rst = 1'b1;
    hold(2);
    check("R8", "fault cleared by reset", rx_fault, 2'b00);
    rst = 1'b0;
    hold(2 * R);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired: got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule